// File: doc/BRIEF.md
# Floating-point control and status register pair

This block holds the two user-visible registers of a small scalar floating-point unit. The control register holds the rounding mode and the enable bits. The status register holds five sticky exception flags. Software writes either register through a single write port and reads either one back through a combinational read port. The current rounding mode goes continuously to the arithmetic datapath. Each cycle, the datapath returns a five-bit vector of exception pulses, and the block ORs these into the status flags.

A build parameter selects one of two write-mask variants. The standard variant keeps only bits 6:0 of a control write. The legacy variant also keeps bits 31:12 and clears only bits 11:7. In the standard variant, a write with any of bits 31:12 set still completes with masking, and it also raises a one-cycle pulse that flags the violation of the must-be-zero bits.

Top module: `fpu_csr`

## Requirements
- R1: After reset, both registers read as zero, the rounding mode output is 0 (round to nearest even) and the violation pulse is low.
- R2: The rounding mode output equals control bits 1:0 one cycle after a control write, with 0 = nearest even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. It does not change without a control write.
- R3: With LEGACY_MASK = 0, a control write (wr_sel_i = 0) stores bits 6:0 of the written data and clears every other bit.
- R4: With LEGACY_MASK = 1, a control write stores bits 6:0 and bits 31:12 of the written data and clears bits 11:7.
- R5: With LEGACY_MASK = 0, a write to either register with any of bits 31:12 set drives mbz_err_o high for exactly the next cycle, and the write still takes effect with masking. A write with those bits clear, and any write with LEGACY_MASK = 1, leaves mbz_err_o low.
- R6: A status write (wr_sel_i = 1) stores only bits 11:7 of the written data.
- R7: A status read (rd_sel_i = 1) returns the flags in bits 11:7 with all other bits zero. From bit 7 upward the flags are inexact, underflow, overflow, divide-by-zero and invalid. exc_i bit 0 is inexact and bit 4 is invalid.
- R8: In every cycle without a status write, each exc_i bit that is high sets its flag, and a set flag stays set.
- R9: When a status write and exception pulses arrive in the same cycle, the status register takes the written value and the pulses are dropped.
- R10: A write to one register, and an exception pulse, leave the control register unchanged when the write is to the other register or when only a pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | DATA_W | Write data |
| exc_i | input | 5 | Exception pulses from the datapath, bit 0 inexact to bit 4 invalid |
| rd_sel_i | input | 1 | Read source: 0 control, 1 status |
| rd_data_o | output | DATA_W | Read data of the selected register |
| rnd_mode_o | output | 2 | Current rounding mode |
| mbz_err_o | output | 1 | One-cycle must-be-zero violation pulse |

## Verification
The hardest case to reach is a status write that lands in the same cycle as a full set of datapath pulses. The priority between the two only shows up when both are present on one clock edge. The stimulus drives exc_i high together with the write strobe, then reads the status back with the pulses removed. Both variants are instantiated side by side on shared inputs. The same out-of-range write then shows the two different masks at once, and shows that the violation pulse appears only in the standard variant.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;
  localparam int unsigned FLAG_W    = 5;
  localparam int unsigned FLAG_LSB  = 7;
  localparam int unsigned CTRL_LO_W = 7;
  localparam int unsigned MBZ_LSB   = 12;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_ZERO      = 2'd1,
    RND_POS_INF   = 2'd2,
    RND_NEG_INF   = 2'd3
  } rnd_mode_e;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } csr_sel_e;

  // packed LSB first: bit 0 inexact .. bit 4 invalid
  typedef struct packed {
    logic invalid;
    logic div_zero;
    logic overflow;
    logic underflow;
    logic inexact;
  } exc_flags_t;
endpackage

// File: rtl/fpu_csr_ctrl.sv
module fpu_csr_ctrl
  import fpu_csr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter bit          LEGACY_MASK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output rnd_mode_e         rnd_o
);
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] ctrl_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < CTRL_LO_W) begin : g_lo
      assign keep_mask[i] = 1'b1;
    end else if (LEGACY_MASK && (i >= MBZ_LSB)) begin : g_hi
      assign keep_mask[i] = 1'b1;
    end else begin : g_clr
      assign keep_mask[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & keep_mask;
  end

  assign ctrl_o = ctrl_q;
  assign rnd_o  = rnd_mode_e'(ctrl_q[1:0]);
endmodule

// File: rtl/fpu_csr_flags.sv
module fpu_csr_flags
  import fpu_csr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  exc_flags_t wflags_i,
  input  exc_flags_t exc_i,
  output exc_flags_t flags_o
);
  exc_flags_t flags_q;

  // software write wins over same-cycle pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (we_i) flags_q <= wflags_i;
    else           flags_q <= flags_q | exc_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fpu_csr_mbz.sv
module fpu_csr_mbz
  import fpu_csr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter bit          LEGACY_MASK = 1'b0,
  localparam int unsigned HI_W       = DATA_W - MBZ_LSB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            viol_o
);
  logic viol_q;
  logic viol_d;

  assign viol_d = we_i && (|hi_i) && !LEGACY_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= viol_d;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/fpu_csr.sv
module fpu_csr
  import fpu_csr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter bit          LEGACY_MASK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [FLAG_W-1:0] exc_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        rnd_mode_o,
  output logic              mbz_err_o
);
  localparam int unsigned FLAG_MSB = FLAG_LSB + FLAG_W - 1;

  logic [DATA_W-1:0] ctrl_q;
  rnd_mode_e         rnd_mode;
  exc_flags_t        flags_q;
  logic              ctrl_we;
  logic              stat_we;
  logic [DATA_W-1:0] stat_view;

  assign ctrl_we = wr_en_i && (csr_sel_e'(wr_sel_i) == SEL_CTRL);
  assign stat_we = wr_en_i && (csr_sel_e'(wr_sel_i) == SEL_STAT);

  fpu_csr_ctrl #(.DATA_W(DATA_W), .LEGACY_MASK(LEGACY_MASK)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (wr_data_i),
    .ctrl_o  (ctrl_q),
    .rnd_o   (rnd_mode)
  );

  fpu_csr_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (stat_we),
    .wflags_i (exc_flags_t'(wr_data_i[FLAG_MSB:FLAG_LSB])),
    .exc_i    (exc_flags_t'(exc_i)),
    .flags_o  (flags_q)
  );

  fpu_csr_mbz #(.DATA_W(DATA_W), .LEGACY_MASK(LEGACY_MASK)) u_mbz (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .hi_i   (wr_data_i[DATA_W-1:MBZ_LSB]),
    .viol_o (mbz_err_o)
  );

  always_comb begin
    stat_view                    = '0;
    stat_view[FLAG_MSB:FLAG_LSB] = flags_q;
  end

  assign rd_data_o  = (csr_sel_e'(rd_sel_i) == SEL_STAT) ? stat_view : ctrl_q;
  assign rnd_mode_o = rnd_mode;
endmodule

// File: rtl/fpu_csr_chk.sv
module fpu_csr_chk
  import fpu_csr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter bit          LEGACY_MASK = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [FLAG_W-1:0] exc_i,
  input logic              rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [1:0]        rnd_mode_o,
  input logic              mbz_err_o,
  input logic [FLAG_W-1:0] flags_q
);
  localparam int unsigned FLAG_MSB = FLAG_LSB + FLAG_W - 1;

  a_r2_rnd_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (rnd_mode_o == $past(wr_data_i[1:0])));

  a_r2_rnd_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !wr_sel_i) |=> $stable(rnd_mode_o));

  a_r5_mbz_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (|wr_data_i[DATA_W-1:MBZ_LSB]) && !LEGACY_MASK) |=> mbz_err_o);

  a_r5_mbz_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbz_err_o |-> ($past(wr_en_i && (|wr_data_i[DATA_W-1:MBZ_LSB])) && !LEGACY_MASK));

  a_r8_sticky_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i) |=> (flags_q == ($past(flags_q) | $past(exc_i))));

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (flags_q == $past(wr_data_i[FLAG_MSB:FLAG_LSB])));

  a_r7_status_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |-> ((rd_data_o[DATA_W-1:MBZ_LSB] == '0) && (rd_data_o[FLAG_LSB-1:0] == '0)
                  && (rd_data_o[FLAG_MSB:FLAG_LSB] == flags_q)));
endmodule

bind fpu_csr fpu_csr_chk #(.DATA_W(DATA_W), .LEGACY_MASK(LEGACY_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .exc_i      (exc_i),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .rnd_mode_o (rnd_mode_o),
  .mbz_err_o  (mbz_err_o),
  .flags_q    (flags_q)
);

// File: tb/fpu_csr_tb.sv
`timescale 1ns/10ps
module fpu_csr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  exc_i = '0;
  logic        rd_sel_i = 1'b0;
  logic [31:0] rd_std, rd_leg;
  logic [1:0]  rnd_std, rnd_leg;
  logic        mbz_std, mbz_leg;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 1'b0;

  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam int K_RD_STD = 0, K_RD_LEG = 1, K_RND = 2, K_MBZ_STD = 3, K_MBZ_LEG = 4;

  always #2.5 clk_i = ~clk_i;

  fpu_csr #(.DATA_W(32), .LEGACY_MASK(1'b0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .exc_i(exc_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_std), .rnd_mode_o(rnd_std), .mbz_err_o(mbz_std));

  fpu_csr #(.DATA_W(32), .LEGACY_MASK(1'b1)) u_dut_leg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .exc_i(exc_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_leg), .rnd_mode_o(rnd_leg), .mbz_err_o(mbz_leg));

  // driver side: queue an expectation for the current state
  task automatic expect_out(input int kind, input logic sel, input logic [31:0] exp, input string tag);
    rd_sel_i = sel;
    kind_q.push_back(kind);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    pushed++;
    #0.1;
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d, input logic [4:0] e);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d; exc_i = e;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0; exc_i = '0;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk_i);
    exc_i = e;
    @(negedge clk_i);
    exc_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // monitor side: pop and compare
  initial begin
    forever begin
      wait (pushed != popped);
      #0.05;
      begin
        int          k;
        logic [31:0] e, a;
        string       t;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        case (k)
          K_RD_STD:  a = rd_std;
          K_RD_LEG:  a = rd_leg;
          K_RND:     a = {30'd0, rnd_std};
          K_MBZ_STD: a = {31'd0, mbz_std};
          default:   a = {31'd0, mbz_leg};
        endcase
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual %08h expected %08h", t, a, e);
        end
      end
      popped++;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    expect_out(K_RD_STD, 1'b0, 32'h0, "R1 ctrl reset");
    expect_out(K_RD_STD, 1'b1, 32'h0, "R1 status reset");
    expect_out(K_RND, 1'b0, 32'h0, "R1 rnd reset");
    expect_out(K_MBZ_STD, 1'b0, 32'h0, "R1 mbz reset");

    // R2 each rounding encoding
    for (int m = 0; m < 4; m++) begin
      write_reg(1'b0, 32'(m), 5'd0);
      expect_out(K_RND, 1'b0, 32'(m), "R2 rnd encoding");
    end
    idle(2);
    expect_out(K_RND, 1'b0, 32'd3, "R2 rnd holds");

    // R3 / R4 / R5 all-ones control write
    write_reg(1'b0, 32'hFFFF_FFFF, 5'd0);
    expect_out(K_MBZ_STD, 1'b0, 32'd1, "R5 mbz pulse on ctrl");
    expect_out(K_MBZ_LEG, 1'b0, 32'd0, "R5 legacy no pulse");
    expect_out(K_RD_STD, 1'b0, 32'h0000_007F, "R3 std ctrl mask");
    expect_out(K_RD_LEG, 1'b0, 32'hFFFF_F07F, "R4 legacy ctrl mask");
    idle(1);
    expect_out(K_MBZ_STD, 1'b0, 32'd0, "R5 pulse one cycle");

    write_reg(1'b0, 32'h0000_0F85, 5'd0);
    expect_out(K_MBZ_STD, 1'b0, 32'd0, "R5 no pulse low bits");
    expect_out(K_RD_STD, 1'b0, 32'h0000_0005, "R3 clears 11:7");
    expect_out(K_RD_LEG, 1'b0, 32'h0000_0005, "R4 clears 11:7");
    expect_out(K_RND, 1'b0, 32'd1, "R2 rnd after masked write");

    // R6 status write masking, R5 on status
    write_reg(1'b1, 32'hFFFF_FFFF, 5'd0);
    expect_out(K_MBZ_STD, 1'b1, 32'd1, "R5 mbz pulse on status");
    expect_out(K_RD_STD, 1'b1, 32'h0000_0F80, "R6 status mask");
    expect_out(K_RD_LEG, 1'b1, 32'h0000_0F80, "R6 legacy status mask");
    expect_out(K_RD_STD, 1'b0, 32'h0000_0005, "R10 ctrl kept on status write");

    // R7 / R8 flag positions and stickiness
    write_reg(1'b1, 32'h0, 5'd0);
    expect_out(K_RD_STD, 1'b1, 32'h0, "R6 status cleared");
    pulse(5'b00001);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0080, "R7 inexact at bit 7");
    pulse(5'b10000);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0880, "R7 invalid at bit 11");
    idle(4);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0880, "R8 flags sticky");
    pulse(5'b00100);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0A80, "R7 overflow at bit 9");
    pulse(5'b01010);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0F80, "R8 underflow and divzero OR in");
    expect_out(K_RD_LEG, 1'b1, 32'h0000_0F80, "R8 legacy flags");
    expect_out(K_RD_STD, 1'b0, 32'h0000_0005, "R10 ctrl kept on pulses");

    // R9 write beats same-cycle pulses
    write_reg(1'b1, 32'h0000_0100, 5'b11111);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0100, "R9 write wins");
    expect_out(K_RD_LEG, 1'b1, 32'h0000_0100, "R9 legacy write wins");
    idle(2);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0100, "R9 pulses dropped");

    // R10 control write leaves flags alone
    write_reg(1'b0, 32'h0000_0002, 5'd0);
    expect_out(K_RD_STD, 1'b1, 32'h0000_0100, "R10 status kept on ctrl write");
    expect_out(K_RND, 1'b0, 32'd2, "R2 toward +inf");

    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule